// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block holds the program counter of a 32-bit processor with fixed-width instructions and works out the address of the next instruction each cycle. Its inputs are the fetched instruction word and the two register values that were read for that instruction's source fields. It recognises the two conditional branches (branch-if-equal and branch-if-not-equal) and the two absolute jumps (plain jump and jump-and-link). It then produces the next address and a flag that marks a change of flow.

A branch offset is a signed count of instructions, not bytes. It is scaled by four and added to the address of the following instruction, PC + 4. A jump keeps the top four bits of PC + 4 and replaces all the lower bits with the 26-bit word index from the instruction. When the enable input is high, the program counter register loads the computed address on each rising clock edge. The link write for jump-and-link and all pipeline concerns belong to other blocks.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0x00000000.
- R2: At a rising edge without reset, `pc` takes the value `next_pc` had before the edge if `en` is high, and keeps its value if `en` is low.
- R3: For any opcode other than 2, 3, 4 or 5, `next_pc` is `pc + 4` and `redirect` is 0, whatever the operand values.
- R4: The opcode is taken from instr[31:26] and the branch offset from instr[15:0]. The rs/rt fields in instr[25:16] do not take part in the comparison; only `rs_val` and `rt_val` do.
- R5: Opcode 4 (branch-if-equal) with `rs_val == rt_val` gives `next_pc = pc + 4 + sext(instr[15:0]) * 4` and `redirect` = 1. Negative offsets move backwards.
- R6: Opcode 4 with unequal operands gives `pc + 4` and `redirect` = 0.
- R7: Opcode 5 (branch-if-not-equal) is taken with the same target formula when the operands differ, and gives `pc + 4` with `redirect` = 0 when they are equal.
- R8: Opcodes 2 (jump) and 3 (jump-and-link) always give `next_pc = {(pc+4)[31:28], instr[25:0], 2'b00}` with `redirect` = 1, whatever the operand values.
- R9: All address arithmetic wraps modulo 2^32. This includes the extreme offsets 0x8000 and 0x7FFF, and the page bits of a jump taken when PC + 4 has wrapped to zero.
- R10: When `pc` is word-aligned, `next_pc` is word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows the PC register to load `next_pc` |
| instr | input | 32 | Instruction word fetched at `pc` |
| rs_val | input | 32 | Value read for the first source register |
| rt_val | input | 32 | Value read for the second source register |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Computed next address (combinational) |
| redirect | output | 1 | High when a branch or jump is taken |

## Verification
The assertions assume that `pc` stays word-aligned and that `instr`, `rs_val` and `rt_val` hold known values at every clock edge after reset. The alignment assumption holds because the reset value and every computed target have their two low bits clear. The stimulus drives all three data inputs from time zero and changes them only on falling edges. It reaches high and wrapped addresses, such as 0xFFFE010C and 0xFFFFFFFC, only through the block's own branches and jumps, so the alignment assumption is never broken.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN  = 32;
    localparam int OPW   = 6;
    localparam int REGW  = 5;
    localparam int IMMW  = 16;
    localparam int JIDXW = XLEN - OPW;          // 26-bit word index
    localparam int PAGEW = XLEN - JIDXW - 2;    // upper bits kept on a jump
    localparam int SEXTW = XLEN - IMMW - 2;     // sign copies before scaling

    localparam logic [OPW-1:0] OPC_JUMP  = 6'd2;
    localparam logic [OPW-1:0] OPC_JLINK = 6'd3;
    localparam logic [OPW-1:0] OPC_BEQ   = 6'd4;
    localparam logic [OPW-1:0] OPC_BNE   = 6'd5;

    typedef enum logic [1:0] {
        XFER_SEQ  = 2'd0,
        XFER_BREQ = 2'd1,
        XFER_BRNE = 2'd2,
        XFER_JUMP = 2'd3
    } xfer_e;

    typedef struct packed {
        logic [OPW-1:0]  opcode;
        logic [REGW-1:0] src_a;
        logic [REGW-1:0] src_b;
        logic [IMMW-1:0] offs;
    } iword_t;

    typedef struct packed {
        xfer_e             kind;
        logic [IMMW-1:0]   offs;
        logic [JIDXW-1:0]  jidx;
    } xfer_t;

    function automatic xfer_e classify(input logic [OPW-1:0] op);
        case (op)
            OPC_BEQ:              return XFER_BREQ;
            OPC_BNE:              return XFER_BRNE;
            OPC_JUMP, OPC_JLINK:  return XFER_JUMP;
            default:              return XFER_SEQ;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] scale_offset(input logic [IMMW-1:0] w);
        return {{SEXTW{w[IMMW-1]}}, w, 2'b00};
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output xfer_t           xfer
);
    iword_t fields;

    always_comb begin
        fields    = iword_t'(instr);
        xfer.kind = classify(fields.opcode);
        xfer.offs = fields.offs;
        xfer.jidx = instr[JIDXW-1:0];
    end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
(
    input  xfer_e           kind,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            taken
);
    logic same;

    always_comb begin
        same = (opa == opb);
        case (kind)
            XFER_BREQ: taken = same;
            XFER_BRNE: taken = !same;
            XFER_JUMP: taken = 1'b1;
            default:   taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] cur_pc,
    input  xfer_t           xfer,
    input  logic            taken,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] rel_pc;
    logic [XLEN-1:0] abs_pc;

    always_comb begin
        seq_pc = cur_pc + XLEN'(4);
        rel_pc = seq_pc + scale_offset(xfer.offs);
        abs_pc = {seq_pc[XLEN-1 -: PAGEW], xfer.jidx, 2'b00};
        if (!taken)
            target = seq_pc;
        else if (xfer.kind == XFER_JUMP)
            target = abs_pc;
        else
            target = rel_pc;
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    output logic [31:0] pc,
    output logic [31:0] next_pc,
    output logic        redirect
);
    logic [XLEN-1:0] pc_q;
    xfer_t           xfer;
    logic            taken;

    npc_decode u_decode (
        .instr (instr),
        .xfer  (xfer)
    );

    npc_cond u_cond (
        .kind  (xfer.kind),
        .opa   (rs_val),
        .opb   (rt_val),
        .taken (taken)
    );

    npc_target u_target (
        .cur_pc (pc_q),
        .xfer   (xfer),
        .taken  (taken),
        .target (next_pc)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_PC;
        else if (en)
            pc_q <= next_pc;
    end

    assign pc       = pc_q;
    assign redirect = taken;

    // Checks kept beside the register and the selection they guard
    logic [XLEN-1:0] chk_seq;
    assign chk_seq = pc_q + 32'd4;

    p_reset_pc_r1: assert property (@(posedge clk)
        rst |=> pc_q == RESET_PC);

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        en |=> pc_q == $past(next_pc));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(pc_q));

    p_fallthrough_r3: assert property (@(posedge clk) disable iff (rst)
        !redirect |-> next_pc == chk_seq);

    p_equal_taken_r5: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == 6'd4 && rs_val == rt_val) |-> redirect);

    p_jump_page_r8: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == 6'd2 || instr[31:26] == 6'd3)
            |-> redirect && next_pc[31:28] == chk_seq[31:28]);

    p_aligned_r10: assert property (@(posedge clk) disable iff (rst)
        pc_q[1:0] == 2'b00 |-> next_pc[1:0] == 2'b00);
endmodule

// File: tb/tb_npc_unit.sv
`timescale 1ns/1ps
module tb_npc_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b1;
    logic [31:0] instr  = 32'h0;
    logic [31:0] rs_val = 32'h0;
    logic [31:0] rt_val = 32'h0;
    logic [31:0] pc;
    logic [31:0] next_pc;
    logic        redirect;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    npc_unit dut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .instr    (instr),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .pc       (pc),
        .next_pc  (next_pc),
        .redirect (redirect)
    );

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] a;
        logic [31:0] b;
        logic        ld;
        logic [31:0] nxt;
        logic        red;
        logic [31:0] pc_after;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        // R3: opcode 0 falls through from 0
        '{32'h0000_0000, 32'd0, 32'd0, 1'b1, 32'h0000_0004, 1'b0, 32'h0000_0004, 8'd3},
        // R5: branch-if-equal, rs=9 rt=0 offset 3, taken -> PC+4+12
        '{32'h1120_0003, 32'd5, 32'd5, 1'b1, 32'h0000_0014, 1'b1, 32'h0000_0014, 8'd5},
        // R6: same word, unequal operands
        '{32'h1120_0003, 32'd5, 32'd6, 1'b1, 32'h0000_0018, 1'b0, 32'h0000_0018, 8'd6},
        // R7: branch-if-not-equal taken, offset 2
        '{32'h1422_0002, 32'd1, 32'd2, 1'b1, 32'h0000_0024, 1'b1, 32'h0000_0024, 8'd7},
        // R7: not taken on equal operands
        '{32'h1422_0002, 32'd7, 32'd7, 1'b1, 32'h0000_0028, 1'b0, 32'h0000_0028, 8'd7},
        // R5: negative offset -2
        '{32'h1000_FFFE, 32'd3, 32'd3, 1'b1, 32'h0000_0024, 1'b1, 32'h0000_0024, 8'd5},
        // R8: jump, unequal operands ignored
        '{32'h0800_0100, 32'd1, 32'd2, 1'b1, 32'h0000_0400, 1'b1, 32'h0000_0400, 8'd8},
        // R8: jump-and-link
        '{32'h0C00_0040, 32'd0, 32'd9, 1'b1, 32'h0000_0100, 1'b1, 32'h0000_0100, 8'd8},
        // R2: enable low, PC holds despite a jump
        '{32'h0800_0200, 32'd0, 32'd0, 1'b0, 32'h0000_0800, 1'b1, 32'h0000_0100, 8'd2},
        // R3: opcode 8 with equal operands
        '{32'h2000_0005, 32'd4, 32'd4, 1'b1, 32'h0000_0104, 1'b0, 32'h0000_0104, 8'd3},
        // R3: opcode 6 with equal operands
        '{32'h1800_0005, 32'd4, 32'd4, 1'b1, 32'h0000_0108, 1'b0, 32'h0000_0108, 8'd3},
        // R9: most negative offset wraps below zero
        '{32'h1000_8000, 32'd0, 32'd0, 1'b1, 32'hFFFE_010C, 1'b1, 32'hFFFE_010C, 8'd9},
        // R8: full word index in the top page
        '{32'h0BFF_FFFF, 32'd0, 32'd0, 1'b1, 32'hFFFF_FFFC, 1'b1, 32'hFFFF_FFFC, 8'd8},
        // R9: jump page comes from wrapped PC+4 (zero); enable low
        '{32'h0800_0001, 32'd0, 32'd0, 1'b0, 32'h0000_0004, 1'b1, 32'hFFFF_FFFC, 8'd9},
        // R9: largest positive offset after wrap
        '{32'h1000_7FFF, 32'd2, 32'd2, 1'b1, 32'h0001_FFFC, 1'b1, 32'h0001_FFFC, 8'd9},
        // R4: rs/rt fields set to 31 do not matter, operands do
        '{32'h13FF_0001, 32'd9, 32'd9, 1'b1, 32'h0002_0004, 1'b1, 32'h0002_0004, 8'd4}
    };

    task automatic check32(input string what, input int req,
                           input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        check32("pc after reset", 1, pc, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            instr  = VEC[i].ins;
            rs_val = VEC[i].a;
            rt_val = VEC[i].b;
            en     = VEC[i].ld;
            #1;
            check32("next_pc", int'(VEC[i].req), next_pc, VEC[i].nxt);
            check32("redirect", int'(VEC[i].req), {31'd0, redirect}, {31'd0, VEC[i].red});
            @(negedge clk);
            check32("pc after edge", int'(VEC[i].req), pc, VEC[i].pc_after);
        end

        // R10: computed address stays aligned from the current PC
        instr = 32'h1000_0010; rs_val = 32'd1; rt_val = 32'd1; en = 1'b1;
        #1;
        check32("next_pc aligned", 10, {30'd0, next_pc[1:0]}, 32'd0);

        // R1: reset in mid-run overrides a pending jump
        rst   = 1'b1;
        instr = 32'h0800_0100;
        @(negedge clk);
        check32("pc on mid-run reset", 1, pc, 32'h0);
        rst = 1'b0;
        #1;
        check32("jump from reset pc", 8, next_pc, 32'h0000_0400);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule